// File: doc/BRIEF.md
# Counter Read Permission Checker

This block rules on whether a read of one of the user-visible counter registers may proceed. A request presents the register address with the privilege level, a virtualization flag, the width and supervisor-presence configuration, the three counter-enable masks (machine, hypervisor, supervisor), a count of configured performance counters and an availability mask. Exactly one verdict comes back: allow, illegal-instruction fault, or virtual-instruction fault. The fault carries its exception cause code.

The address selects a single bit position, and that one index serves every mask. The three fixed counters (cycle, time, retired instructions) sit at positions 0 to 2. The programmable counters fill positions 3 to 31. Checks run in a fixed order and the first failing check decides the verdict. Addresses outside the counter windows are flagged as such and get no verdict.

Top module: `counterGate`

## Requirements
- R1: A response appears on the clock edge that samples `reqValid` high: `rspValid` is high for exactly that one cycle, and it is low in every cycle after a cycle with `reqValid` low.
- R2: Address 0xC00+i (i = 0..31) selects counter bit i. Address 0xC80+i selects bit i only when `isRv32` is 1. Any other address sets `notCounter`=1 with `rspCode`=00 and `rspCause`=0.
- R3: Bits 0, 1 and 2 (the fixed counters) are never subject to the performance-counter availability check.
- R4: For bit i ≥ 3, the verdict is illegal when `pmuCount` is 0 or `availMask[i]` is 0. This holds at every privilege level and takes precedence over all mask checks.
- R5: With `privLvl`=3 (machine), a counter access that passes R4 is allowed, whatever the enable masks and `virtOn` hold.
- R6: With `privLvl` below 3 (0 = user, 1 = supervisor), `mEnMask[i]`=0 gives illegal, ahead of the hypervisor and supervisor checks.
- R7: With `virtOn`=1 and `privLvl` below 3, `hEnMask[i]`=0 gives virtual-instruction, once R4 and R6 pass.
- R8: With `hasSExt`=1 and `privLvl`=0, `sEnMask[i]`=0 gives illegal when `virtOn`=0 and virtual-instruction when `virtOn`=1. With `hasSExt`=0, `sEnMask` has no effect.
- R9: The code is 00 for allow (cause 0), 01 for illegal (cause 2) and 10 for virtual-instruction (cause 22). Code 11 never appears.
- R10: After reset, `rspValid`, `rspCode`, `rspCause` and `notCounter` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| csrAddr | input | 12 | Counter register address |
| privLvl | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virtOn | input | 1 | Hart runs virtualized |
| isRv32 | input | 1 | 32-bit mode; enables upper-half addresses |
| hasSExt | input | 1 | Supervisor mode implemented |
| mEnMask | input | 32 | Machine counter-enable mask |
| hEnMask | input | 32 | Hypervisor counter-enable mask |
| sEnMask | input | 32 | Supervisor counter-enable mask |
| pmuCount | input | 5 | Number of configured programmable counters |
| availMask | input | 32 | Available programmable counter mask |
| rspValid | output | 1 | Verdict valid |
| rspCode | output | 2 | Verdict code |
| rspCause | output | 5 | Exception cause for the verdict |
| notCounter | output | 1 | Address is not a counter |

## Verification
Each verdict, with its cause and `notCounter`, is registered once and becomes visible on the clock edge that samples the request. The bench therefore drives a request on a falling edge, lets one rising edge pass, and compares on the next falling edge, so every sample falls half a period clear of any register update. The sweep covers every address in both counter windows plus addresses just outside them. It crosses each address with every privilege level, virtualization, width and supervisor setting, over several mask patterns, including one with zero programmable counters. An idle cycle checks that `rspValid` drops.

// File: rtl/counterGatePkg.sv
package counterGatePkg;

  typedef enum logic [1:0] {
    VERD_OK   = 2'b00,
    VERD_ILL  = 2'b01,
    VERD_VIRT = 2'b10
  } verdict_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // raw per-request facts produced by the datapath
  typedef struct packed {
    logic noCtr;
    logic pmuFail;
    logic mClr;
    logic hClr;
    logic sClr;
  } chkFlags_t;

  // strobes from control back to the datapath
  typedef struct packed {
    logic     load;
    logic     noCtr;
    verdict_e verdict;
  } ctlStrobe_t;

endpackage

// File: rtl/counterGateDp.sv
module counterGateDp
  import counterGatePkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CTR   = 32,
  parameter int FIXED_NUM = 3,
  parameter int PMU_W     = 5,
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_ILL = 2,
  parameter int CAUSE_VRT = 22,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 12'hC00,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 12'hC80
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   csrAddr,
  input  logic                isRv32,
  input  logic [NUM_CTR-1:0]  mEnMask,
  input  logic [NUM_CTR-1:0]  hEnMask,
  input  logic [NUM_CTR-1:0]  sEnMask,
  input  logic [PMU_W-1:0]    pmuCount,
  input  logic [NUM_CTR-1:0]  availMask,
  input  ctlStrobe_t          strobe,
  output chkFlags_t           flags,
  output logic                rspValid,
  output logic [1:0]          rspCode,
  output logic [CAUSE_W-1:0]  rspCause,
  output logic                notCounter
);

  localparam int IDX_W = $clog2(NUM_CTR);
  localparam logic [ADDR_W-1:0]  SPAN    = ADDR_W'(NUM_CTR);
  localparam logic [IDX_W-1:0]   FIX_LIM = IDX_W'(FIXED_NUM);

  logic [ADDR_W-1:0]  offLo, offHi;
  logic               inLow, inHigh, isFixed;
  logic [IDX_W-1:0]   idx;
  logic [NUM_CTR-1:0] oneHot;
  logic               mBit, hBit, sBit, aBit;

  assign offLo  = csrAddr - LOW_BASE;
  assign offHi  = csrAddr - HIGH_BASE;
  assign inLow  = (offLo < SPAN);
  assign inHigh = isRv32 && (offHi < SPAN);
  assign idx    = inLow ? offLo[IDX_W-1:0] : offHi[IDX_W-1:0];

  // one decoded select line per counter position
  for (genvar g = 0; g < NUM_CTR; g++) begin : gSel
    assign oneHot[g] = (idx == IDX_W'(g));
  end

  assign mBit    = |(mEnMask   & oneHot);
  assign hBit    = |(hEnMask   & oneHot);
  assign sBit    = |(sEnMask   & oneHot);
  assign aBit    = |(availMask & oneHot);
  assign isFixed = (idx < FIX_LIM);

  always_comb begin
    flags.noCtr   = !(inLow || inHigh);
    flags.pmuFail = !isFixed && ((pmuCount == '0) || !aBit);
    flags.mClr    = !mBit;
    flags.hClr    = !hBit;
    flags.sClr    = !sBit;
  end

  function automatic logic [CAUSE_W-1:0] causeOf(verdict_e v);
    case (v)
      VERD_ILL:  causeOf = CAUSE_W'(CAUSE_ILL);
      VERD_VIRT: causeOf = CAUSE_W'(CAUSE_VRT);
      default:   causeOf = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspCode    <= 2'b00;
      rspCause   <= '0;
      notCounter <= 1'b0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspCode    <= strobe.verdict;
        rspCause   <= causeOf(strobe.verdict);
        notCounter <= strobe.noCtr;
      end
    end
  end

endmodule

// File: rtl/counterGateCtl.sv
module counterGateCtl
  import counterGatePkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] privLvl,
  input  logic       virtOn,
  input  logic       hasSExt,
  input  chkFlags_t  flags,
  output ctlStrobe_t strobe
);

  logic belowM, guestRun, userRun;

  assign belowM   = (privLvl != PRIV_M);
  assign guestRun = virtOn && belowM;
  assign userRun  = (privLvl == PRIV_U);

  // first failing check wins
  always_comb begin
    strobe.load  = reqValid;
    strobe.noCtr = flags.noCtr;
    if (flags.noCtr)                          strobe.verdict = VERD_OK;
    else if (flags.pmuFail)                   strobe.verdict = VERD_ILL;
    else if (!belowM)                         strobe.verdict = VERD_OK;
    else if (flags.mClr)                      strobe.verdict = VERD_ILL;
    else if (guestRun && flags.hClr)          strobe.verdict = VERD_VIRT;
    else if (hasSExt && userRun && flags.sClr)
      strobe.verdict = guestRun ? VERD_VIRT : VERD_ILL;
    else                                      strobe.verdict = VERD_OK;
  end

endmodule

// File: rtl/counterGate.sv
module counterGate
  import counterGatePkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_CTR = 32,
  parameter int PMU_W   = 5,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  csrAddr,
  input  logic [1:0]         privLvl,
  input  logic               virtOn,
  input  logic               isRv32,
  input  logic               hasSExt,
  input  logic [NUM_CTR-1:0] mEnMask,
  input  logic [NUM_CTR-1:0] hEnMask,
  input  logic [NUM_CTR-1:0] sEnMask,
  input  logic [PMU_W-1:0]   pmuCount,
  input  logic [NUM_CTR-1:0] availMask,
  output logic               rspValid,
  output logic [1:0]         rspCode,
  output logic [CAUSE_W-1:0] rspCause,
  output logic               notCounter
);

  chkFlags_t  flags;
  ctlStrobe_t strobe;

  counterGateDp #(
    .ADDR_W (ADDR_W),
    .NUM_CTR(NUM_CTR),
    .PMU_W  (PMU_W),
    .CAUSE_W(CAUSE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .csrAddr   (csrAddr),
    .isRv32    (isRv32),
    .mEnMask   (mEnMask),
    .hEnMask   (hEnMask),
    .sEnMask   (sEnMask),
    .pmuCount  (pmuCount),
    .availMask (availMask),
    .strobe    (strobe),
    .flags     (flags),
    .rspValid  (rspValid),
    .rspCode   (rspCode),
    .rspCause  (rspCause),
    .notCounter(notCounter)
  );

  counterGateCtl u_ctl (
    .reqValid(reqValid),
    .privLvl (privLvl),
    .virtOn  (virtOn),
    .hasSExt (hasSExt),
    .flags   (flags),
    .strobe  (strobe)
  );

endmodule

// File: rtl/counterGateChk.sv
module counterGateChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [11:0] csrAddr,
  input logic [1:0]  privLvl,
  input logic        isRv32,
  input logic [4:0]  pmuCount,
  input logic        rspValid,
  input logic [1:0]  rspCode,
  input logic [4:0]  rspCause,
  input logic        notCounter
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R1
  AST_HIGH_NEEDS_RV32: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isRv32 && csrAddr[11:5] == 7'h64) |=> notCounter); // R2
  AST_NOCTR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    notCounter |-> (rspCode == 2'b00 && rspCause == 5'd0)); // R2
  AST_FIXED_M_OK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && privLvl == 2'd3 && csrAddr[11:5] == 7'h60 && csrAddr[4:0] < 5'd3)
      |=> rspCode == 2'b00); // R3
  AST_PMU_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pmuCount == 5'd0 && csrAddr[11:5] == 7'h60 && csrAddr[4:0] >= 5'd3)
      |=> rspCode == 2'b01); // R4
  AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rstN)
    rspCode != 2'b11); // R9
  AST_CAUSE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspCode == 2'b00 && rspCause == 5'd0) ||
                  (rspCode == 2'b01 && rspCause == 5'd2) ||
                  (rspCode == 2'b10 && rspCause == 5'd22))); // R9

endmodule

bind counterGate counterGateChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .csrAddr   (csrAddr),
  .privLvl   (privLvl),
  .isRv32    (isRv32),
  .pmuCount  (pmuCount),
  .rspValid  (rspValid),
  .rspCode   (rspCode),
  .rspCause  (rspCause),
  .notCounter(notCounter)
);

// File: tb/counterGate_tb.sv
module counterGate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0]  privLvl = '0;
  logic        virtOn = 1'b0, isRv32 = 1'b0, hasSExt = 1'b0;
  logic [31:0] mEnMask = '0, hEnMask = '0, sEnMask = '0, availMask = '0;
  logic [4:0]  pmuCount = '0;
  logic        rspValid, notCounter;
  logic [1:0]  rspCode;
  logic [4:0]  rspCause;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  counterGate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .csrAddr(csrAddr),
    .privLvl(privLvl), .virtOn(virtOn), .isRv32(isRv32), .hasSExt(hasSExt),
    .mEnMask(mEnMask), .hEnMask(hEnMask), .sEnMask(sEnMask),
    .pmuCount(pmuCount), .availMask(availMask),
    .rspValid(rspValid), .rspCode(rspCode), .rspCause(rspCause),
    .notCounter(notCounter)
  );

  // expected verdict from the requirements; tag names the deciding one
  task automatic refModel(output logic [1:0] code, output logic nc, output string tag);
    int a, i;
    a = int'(csrAddr);
    code = 2'b00; nc = 1'b0; tag = "R5";
    if (a >= 'hC00 && a <= 'hC1F) i = a - 'hC00;
    else if (isRv32 && a >= 'hC80 && a <= 'hC9F) i = a - 'hC80;
    else begin nc = 1'b1; tag = "R2"; return; end
    if (i >= 3 && (pmuCount == 0 || !availMask[i])) begin code = 2'b01; tag = "R4"; return; end
    if (privLvl == 2'd3) begin tag = (i < 3) ? "R3" : "R5"; return; end
    if (!mEnMask[i]) begin code = 2'b01; tag = "R6"; return; end
    if (virtOn && !hEnMask[i]) begin code = 2'b10; tag = "R7"; return; end
    if (hasSExt && privLvl == 2'd0 && !sEnMask[i]) begin
      code = virtOn ? 2'b10 : 2'b01; tag = "R8"; return;
    end
    tag = "R8";
  endtask

  task automatic applyOne();
    logic [1:0] eCode; logic eNc; string tag; logic [4:0] eCause;
    refModel(eCode, eNc, tag);
    eCause = (eCode == 2'b01) ? 5'd2 : (eCode == 2'b10) ? 5'd22 : 5'd0; // R9
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    nChecks++;
    if (rspValid !== 1'b1 || rspCode !== eCode || rspCause !== eCause || notCounter !== eNc) begin
      nFails++;
      $display("FAIL %s/R1/R9 addr=%h priv=%0d v=%0b rv32=%0b s=%0b: got vld=%0b code=%b cause=%0d nc=%0b exp vld=1 code=%b cause=%0d nc=%0b",
               tag, csrAddr, privLvl, virtOn, isRv32, hasSExt,
               rspValid, rspCode, rspCause, notCounter, eCode, eCause, eNc);
    end
  endtask

  function automatic logic [11:0] addrAt(int n);
    if (n < 32) return 12'(12'hC00 + n);
    if (n < 64) return 12'(12'hC80 + n - 32);
    case (n)
      64: return 12'hC20;
      65: return 12'hBFF;
      66: return 12'hC7F;
      67: return 12'hCA0;
      default: return 12'h000;
    endcase
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nChecks++; // R10 reset state
    if (rspValid !== 1'b0 || rspCode !== 2'b00 || rspCause !== 5'd0 || notCounter !== 1'b0) begin
      nFails++;
      $display("FAIL R10: got vld=%0b code=%b cause=%0d nc=%0b exp all zero",
               rspValid, rspCode, rspCause, notCounter);
    end
    rstN = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      mEnMask   = (k == 4) ? '1 : ~(32'h0101_0109 << k);
      hEnMask   = (k == 4) ? '1 : ~(32'h0204_0412 << k);
      sEnMask   = (k == 4) ? '1 : ~(32'h1008_2024 << k);
      availMask = (k == 4) ? '1 : ~(32'h4020_0840 << k);
      pmuCount  = (k == 3) ? 5'd0 : 5'd29;
      for (int n = 0; n < 69; n++) begin
        csrAddr = addrAt(n);
        for (int p = 0; p < 3; p++) begin
          privLvl = (p == 2) ? 2'd3 : 2'(p);
          for (int c = 0; c < 8; c++) begin
            virtOn  = c[0];
            isRv32  = c[1];
            hasSExt = c[2];
            applyOne();
          end
        end
      end
    end
    // idle cycle: response strobe must drop (R1)
    @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (rspValid !== 1'b0) begin
      nFails++;
      $display("FAIL R1 idle: got vld=%0b exp 0", rspValid);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule